// File: doc/BRIEF.md
# Destructive-Read Memory Array Sequencer

This block is a synchronous controller for a small modelled memory array built from one-transistor-one-capacitor cells. It takes read and write requests that carry a full address. It then steps the array through a fixed phase order: bitline precharge, row activation, a charge-sharing wait, sensing, column select, restore and close. The row and column halves of the address leave over one shared multiplexed port, each marked by its own strobe. A one-hot wordline, a sense enable and a one-hot column select mark which part of the array is live in each cycle.

The array is a register model in which opening a row empties that row, just as a real destructive read does. The sensed row buffer must be written back while the wordline is still high, so a skipped restore shows up as lost data. A built-in timer raises a refresh request at a fixed period. The request waits for any access in flight to finish, and it wins over new requests. Refresh opens the next row in turn, restores it and closes it, and the row counter wraps after the last row.

Top module: `dram_seq`

## Requirements
- R1: The row index leaves on `mux_addr` with `ras` high, during every cycle of the activation wait. The column index leaves later on the same port with `cas` high, in the single column cycle. `ras` and `cas` are never high together. When neither is high, `mux_addr` is zero. The port is max(log2 ROWS, log2 COLS) bits wide.
- R2: Every activation, whether for an access or for a refresh, follows exactly T_PRE cycles with `precharge` high. `precharge` is never high while a wordline is high.
- R3: `wordline` is all-zero or has exactly one bit set. Bit i stands for row i.
- R4: `sense_en` rises only after the wordline has been high for T_ACT cycles. It stays high through the column and restore phases, and it is low whenever no wordline is high.
- R5: For an access, `col_sel` has exactly one bit set, for bit c of column c. This lasts exactly one cycle and comes T_SNS cycles after `sense_en` rises, with the wordline and sense enable both high.
- R6: A read returns the word last written to that address, or zero if none, on `rd_data`. The word comes with a one-cycle `rd_valid` pulse in the cycle right after the column cycle. Writes produce no `rd_valid`.
- R7: After the column cycle (or after sensing, for a refresh), `restore` is high for T_RST cycles with the same wordline held. Repeated reads and refreshes of a row leave its contents unchanged.
- R8: A refresh is raised every REF_PERIOD cycles. It runs precharge, activation, sensing and restore with no `cas` and no `col_sel`. It visits rows 0, 1, … ROWS-1 and then wraps to row 0.
- R9: A pending refresh waits for the access in flight to finish and starts ahead of any waiting request. While it is pending, `req_ready` is low.
- R10: `req_ready` is high only while the sequencer is idle. A request is taken at the clock edge where `req_valid` and `req_ready` are both high. `req_addr` holds the row in its upper bits and the column in its lower bits. A write changes only the addressed word.
- R11: During reset all strobes, `wordline`, `col_sel` and `rd_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | log2 ROWS + log2 COLS | Row in upper bits, column in lower bits |
| req_wdata | input | DW | Write word |
| rd_valid | output | 1 | One-cycle read-data pulse |
| rd_data | output | DW | Read word |
| mux_addr | output | max(log2 ROWS, log2 COLS) | Shared row/column address port |
| ras | output | 1 | Row address strobe |
| cas | output | 1 | Column address strobe |
| precharge | output | 1 | Bitline precharge phase |
| wordline | output | ROWS | One-hot row enable |
| sense_en | output | 1 | Sense amplifier enable |
| col_sel | output | COLS | One-hot column select |
| restore | output | 1 | Write-back phase |

## Verification
The bound checker watches the phase relations on every cycle. It confirms that the wordline is at most one-hot, that column select and sense never appear without a wordline, and that the wordline is held steady once open. It also confirms that precharge comes before each rise of the wordline, that the two address strobes never overlap, that read data follows a column select, and that the block is ready only while idle. What the checker cannot show is that data survives destructive activation. The same holds for the exact phase lengths, the refresh cadence and row order, and a refresh taking the lead over a waiting request. The bench shows these by running writes, repeated reads, long idle spans and back-to-back traffic against its cycle-accurate model.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_ACT  = 3'd2,
    PH_SNS  = 3'd3,
    PH_COL  = 3'd4,
    PH_RST  = 3'd5
  } phase_e;
endpackage

// File: rtl/dram_seq_onehot.sv
module dram_seq_onehot #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  vec
);
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign vec[i] = en && (idx == IW'(i));
  end
endmodule

// File: rtl/dram_seq_refresh.sv
module dram_seq_refresh #(
  parameter int ROWS       = 8,
  parameter int REF_PERIOD = 64,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int TW = (REF_PERIOD > 1) ? $clog2(REF_PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  output logic          pend,
  output logic [RW-1:0] row
);
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_d;
  logic [RW-1:0] row_d;
  logic          tick;

  assign tick = (tmr_q == TW'(REF_PERIOD - 1));

  always_comb begin
    tmr_d  = tick ? '0 : tmr_q + 1'b1;
    pend_d = pend;
    if (take) pend_d = 1'b0;
    if (tick) pend_d = 1'b1;
    row_d  = row;
    if (take) row_d = (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      pend  <= 1'b0;
      row   <= '0;
    end else begin
      tmr_q <= tmr_d;
      pend  <= pend_d;
      row   <= row_d;
    end
  end
endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm import dram_seq_pkg::*; #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DW    = 8,
  parameter int T_PRE = 2,
  parameter int T_ACT = 3,
  parameter int T_SNS = 2,
  parameter int T_RST = 2,
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CLW  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int TMX1 = (T_PRE > T_ACT) ? T_PRE : T_ACT,
  localparam int TMX2 = (T_SNS > T_RST) ? T_SNS : T_RST,
  localparam int TMAX = (TMX1 > TMX2) ? TMX1 : TMX2,
  localparam int CW   = $clog2(TMAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_we,
  input  logic [RW-1:0]  req_row,
  input  logic [CLW-1:0] req_col,
  input  logic [DW-1:0]  req_wdata,
  input  logic           ref_pend,
  input  logic [RW-1:0]  ref_row,
  output phase_e         phase,
  output logic           req_ready,
  output logic           ref_take,
  output logic           act_first,
  output logic [RW-1:0]  cur_row,
  output logic [CLW-1:0] cur_col,
  output logic           cur_we,
  output logic [DW-1:0]  cur_wdata
);
  localparam logic [CW-1:0] C_PRE = CW'(T_PRE - 1);
  localparam logic [CW-1:0] C_ACT = CW'(T_ACT - 1);
  localparam logic [CW-1:0] C_SNS = CW'(T_SNS - 1);
  localparam logic [CW-1:0] C_RST = CW'(T_RST - 1);

  phase_e        ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_ref_q;
  logic          load;
  logic          done;

  assign done      = (cnt_q == '0);
  assign req_ready = (phase == PH_IDLE) && !ref_pend;
  assign ref_take  = (phase == PH_IDLE) && ref_pend;
  assign load      = (phase == PH_IDLE) && (ref_pend || req_valid);
  assign act_first = (phase == PH_ACT) && (cnt_q == C_ACT);

  always_comb begin
    ph_d  = phase;
    cnt_d = done ? cnt_q : cnt_q - 1'b1;
    case (phase)
      PH_IDLE: if (load) begin
        ph_d  = PH_PRE;
        cnt_d = C_PRE;
      end
      PH_PRE: if (done) begin
        ph_d  = PH_ACT;
        cnt_d = C_ACT;
      end
      PH_ACT: if (done) begin
        ph_d  = PH_SNS;
        cnt_d = C_SNS;
      end
      PH_SNS: if (done) begin
        ph_d  = is_ref_q ? PH_RST : PH_COL;
        cnt_d = C_RST;
      end
      PH_COL: begin
        ph_d  = PH_RST;
        cnt_d = C_RST;
      end
      PH_RST: if (done) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      phase <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_ref_q  <= 1'b0;
      cur_row   <= '0;
      cur_col   <= '0;
      cur_we    <= 1'b0;
      cur_wdata <= '0;
    end else if (load) begin
      is_ref_q  <= ref_pend;
      cur_row   <= ref_pend ? ref_row : req_row;
      cur_col   <= req_col;
      cur_we    <= !ref_pend && req_we;
      cur_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/dram_seq_array.sv
module dram_seq_array #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 8,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           act_first,
  input  logic           restore_en,
  input  logic           col_wr,
  input  logic           col_rd,
  input  logic [RW-1:0]  row,
  input  logic [CLW-1:0] col,
  input  logic [DW-1:0]  wdata,
  output logic           rd_valid,
  output logic [DW-1:0]  rd_data
);
  logic [DW-1:0] cells [ROWS][COLS];
  logic [DW-1:0] rbuf  [COLS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
      for (int c = 0; c < COLS; c++) rbuf[c] <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (act_first) begin
        for (int c = 0; c < COLS; c++) begin
          rbuf[c]       <= cells[row][c];
          cells[row][c] <= '0;
        end
      end
      if (col_wr) rbuf[col] <= wdata;
      if (restore_en) begin
        for (int c = 0; c < COLS; c++) cells[row][c] <= rbuf[c];
      end
      rd_valid <= col_rd;
      if (col_rd) rd_data <= rbuf[col];
    end
  end
endmodule

// File: rtl/dram_seq.sv
module dram_seq import dram_seq_pkg::*; #(
  parameter int ROWS       = 8,
  parameter int COLS       = 8,
  parameter int DW         = 8,
  parameter int T_PRE      = 2,
  parameter int T_ACT      = 3,
  parameter int T_SNS      = 2,
  parameter int T_RST      = 2,
  parameter int REF_PERIOD = 64,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CLW = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int AW  = RW + CLW,
  localparam int MAW = (RW > CLW) ? RW : CLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_we,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic [MAW-1:0]  mux_addr,
  output logic            ras,
  output logic            cas,
  output logic            precharge,
  output logic [ROWS-1:0] wordline,
  output logic            sense_en,
  output logic [COLS-1:0] col_sel,
  output logic            restore
);
  phase_e         phase;
  logic           ref_pend, ref_take, act_first, cur_we, wl_on;
  logic [RW-1:0]  ref_row, cur_row;
  logic [CLW-1:0] cur_col;
  logic [DW-1:0]  cur_wdata;

  dram_seq_refresh #(.ROWS(ROWS), .REF_PERIOD(REF_PERIOD)) u_ref (
    .clk(clk), .rst_n(rst_n), .take(ref_take), .pend(ref_pend), .row(ref_row)
  );

  dram_seq_fsm #(
    .ROWS(ROWS), .COLS(COLS), .DW(DW),
    .T_PRE(T_PRE), .T_ACT(T_ACT), .T_SNS(T_SNS), .T_RST(T_RST)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_we(req_we),
    .req_row(req_addr[AW-1:CLW]), .req_col(req_addr[CLW-1:0]),
    .req_wdata(req_wdata), .ref_pend(ref_pend), .ref_row(ref_row),
    .phase(phase), .req_ready(req_ready), .ref_take(ref_take),
    .act_first(act_first), .cur_row(cur_row), .cur_col(cur_col),
    .cur_we(cur_we), .cur_wdata(cur_wdata)
  );

  assign precharge = (phase == PH_PRE);
  assign ras       = (phase == PH_ACT);
  assign cas       = (phase == PH_COL);
  assign restore   = (phase == PH_RST);
  assign sense_en  = (phase == PH_SNS) || cas || restore;
  assign wl_on     = ras || sense_en;
  assign mux_addr  = ras ? MAW'(cur_row) : (cas ? MAW'(cur_col) : '0);

  dram_seq_onehot #(.N(ROWS)) u_wl_dec (.en(wl_on), .idx(cur_row), .vec(wordline));
  dram_seq_onehot #(.N(COLS)) u_col_dec (.en(cas), .idx(cur_col), .vec(col_sel));

  dram_seq_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_arr (
    .clk(clk), .rst_n(rst_n), .act_first(act_first), .restore_en(restore),
    .col_wr(cas && cur_we), .col_rd(cas && !cur_we),
    .row(cur_row), .col(cur_col), .wdata(cur_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] wordline,
  input logic [COLS-1:0] col_sel,
  input logic            sense_en,
  input logic            precharge,
  input logic            restore,
  input logic            ras,
  input logic            cas,
  input logic            rd_valid,
  input logic            req_ready
);
  a_r3_wl_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wordline));

  a_r5_col_onehot_open: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_sel) |-> ($onehot(col_sel) && (|wordline) && sense_en));

  a_r4_sense_needs_wl: assert property (@(posedge clk) disable iff (!rst_n)
    sense_en |-> (|wordline));

  a_r7_restore_holds_wl: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> ((|wordline) && sense_en));

  a_r7_wl_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wordline) && (|$past(wordline))) |-> (wordline == $past(wordline)));

  a_r2_pre_before_act: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|wordline) |-> $past(precharge));

  a_r2_pre_no_wl: assert property (@(posedge clk) disable iff (!rst_n)
    precharge |-> !(|wordline));

  a_r1_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras && cas));

  a_r6_rdv_after_col: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_rdv_follows_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(cas));

  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!(|wordline) && !precharge));
endmodule

bind dram_seq dram_seq_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wordline(wordline), .col_sel(col_sel),
  .sense_en(sense_en), .precharge(precharge), .restore(restore),
  .ras(ras), .cas(cas), .rd_valid(rd_valid), .req_ready(req_ready)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
  localparam int ROWS = 8, COLS = 8, DW = 8;
  localparam int T_PRE = 2, T_ACT = 3, T_SNS = 2, T_RST = 2, REF_PERIOD = 64;
  localparam int RW = $clog2(ROWS), CLW = $clog2(COLS), AW = RW + CLW;
  localparam int MAW = (RW > CLW) ? RW : CLW;

  typedef struct packed {
    logic pre, ras, cas, sen, rst, rdv, wlon, colon;
    logic [RW-1:0] row;
    logic [CLW-1:0] col;
    logic [DW-1:0] rdd;
  } cyc_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ras, cas, precharge, sense_en, restore;
  logic [DW-1:0] rd_data;
  logic [MAW-1:0] mux_addr;
  logic [ROWS-1:0] wordline;
  logic [COLS-1:0] col_sel;

  int n_chk = 0, n_err = 0;
  bit run = 0, ended = 0;
  cyc_t exp_q[$];
  logic [DW-1:0] mm [ROWS][COLS];
  int tcnt = 0, rrow = 0;
  bit pend = 0;

  always #10 clk = ~clk;

  dram_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mux_addr(mux_addr),
    .ras(ras), .cas(cas), .precharge(precharge), .wordline(wordline),
    .sense_en(sense_en), .col_sel(col_sel), .restore(restore)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s t=%0t act=%0h exp=%0h", req, $time, act, expv);
    end
  endtask

  task automatic push_op(input bit is_ref, input int row, input int col,
                         input bit we, input logic [DW-1:0] wd);
    cyc_t s;
    for (int i = 0; i < T_PRE; i++) begin s = '0; s.pre = 1; exp_q.push_back(s); end
    for (int i = 0; i < T_ACT; i++) begin
      s = '0; s.wlon = 1; s.ras = 1; s.row = RW'(row); exp_q.push_back(s);
    end
    for (int i = 0; i < T_SNS; i++) begin
      s = '0; s.wlon = 1; s.sen = 1; s.row = RW'(row); exp_q.push_back(s);
    end
    if (!is_ref) begin
      s = '0; s.wlon = 1; s.sen = 1; s.cas = 1; s.colon = 1;
      s.row = RW'(row); s.col = CLW'(col); exp_q.push_back(s);
      if (we) mm[row][col] = wd;
    end
    for (int i = 0; i < T_RST; i++) begin
      s = '0; s.wlon = 1; s.sen = 1; s.rst = 1; s.row = RW'(row);
      if (i == 0 && !is_ref && !we) begin s.rdv = 1; s.rdd = mm[row][col]; end
      exp_q.push_back(s);
    end
  endtask

  // cycle-by-cycle reference model, stepped between edges
  always @(negedge clk) begin
    if (run && !ended) begin
      cyc_t e;
      bit idle;
      logic [ROWS-1:0] wl_e;
      logic [COLS-1:0] cs_e;
      logic [MAW-1:0] ma_e;
      idle = (exp_q.size() == 0);
      e = idle ? cyc_t'(0) : exp_q[0];
      wl_e = e.wlon ? (ROWS'(1) << e.row) : '0;
      cs_e = e.colon ? (COLS'(1) << e.col) : '0;
      ma_e = e.ras ? MAW'(e.row) : (e.cas ? MAW'(e.col) : '0);
      chk("R3 wordline", 32'(wordline), 32'(wl_e));
      chk("R2 precharge", 32'(precharge), 32'(e.pre));
      chk("R1 ras", 32'(ras), 32'(e.ras));
      chk("R1 cas", 32'(cas), 32'(e.cas));
      chk("R1 mux_addr", 32'(mux_addr), 32'(ma_e));
      chk("R4 sense_en", 32'(sense_en), 32'(e.sen));
      chk("R5 col_sel", 32'(col_sel), 32'(cs_e));
      chk("R7 restore", 32'(restore), 32'(e.rst));
      chk("R6 rd_valid", 32'(rd_valid), 32'(e.rdv));
      if (e.rdv) chk("R6 rd_data", 32'(rd_data), 32'(e.rdd));
      chk("R9 req_ready", 32'(req_ready), 32'(idle && !pend));
      // predict the coming edge
      if (!idle) void'(exp_q.pop_front());
      else if (pend) begin
        push_op(1, rrow, 0, 0, '0);       // R8 refresh, row order with wrap
        rrow = (rrow == ROWS - 1) ? 0 : rrow + 1;
        pend = 0;
      end else if (req_valid)
        push_op(0, int'(req_addr[AW-1:CLW]), int'(req_addr[CLW-1:0]), req_we, req_wdata);
      if (tcnt == REF_PERIOD - 1) begin tcnt = 0; pend = 1; end
      else tcnt++;
    end
  end

  task automatic op(input bit we, input int row, input int col, input logic [DW-1:0] wd);
    bit acc;
    req_valid = 1; req_we = we; req_addr = {RW'(row), CLW'(col)}; req_wdata = wd;
    do begin
      @(negedge clk); acc = req_ready;
      @(posedge clk); #1;
    end while (!acc);
    req_valid = 0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    ended = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++) for (int c = 0; c < COLS; c++) mm[r][c] = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 wordline", 32'(wordline), 32'd0);
    chk("R11 strobes", 32'({precharge, ras, cas, sense_en, restore}), 32'd0);
    chk("R11 col_sel", 32'(col_sel), 32'd0);
    chk("R11 rd_valid", 32'(rd_valid), 32'd0);
    chk("R11 req_ready", 32'(req_ready), 32'd1);
    @(posedge clk); #1;
    rst_n = 1; run = 1;
    idle_cycles(2);
    // R10 writes to scattered words
    op(1, 1, 2, 8'hA5); op(1, 1, 5, 8'h3C); op(1, 7, 7, 8'hFF); op(1, 0, 0, 8'h11);
    // R6 R7 reads, repeated read of one word survives destructive activation
    op(0, 1, 2, 0); op(0, 1, 2, 0); op(0, 1, 5, 0); op(0, 7, 7, 0);
    op(0, 0, 0, 0); op(0, 4, 4, 0);
    // R8 long idle span: many refreshes, row counter wraps
    idle_cycles(700);
    op(0, 1, 2, 0); op(0, 1, 5, 0); op(0, 7, 7, 0); op(0, 0, 0, 0);
    // R9 back-to-back traffic, refresh collides with waiting requests
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) op(1, r, c, DW'(r * 17 + c * 5 + 3));
    for (int r = ROWS - 1; r >= 0; r--)
      for (int c = 0; c < COLS; c++) op(0, r, c, 0);
    idle_cycles(40);
    finish_run();
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end
endmodule